// File: doc/BRIEF.md
# JTAG Debug Port Scan Controller

This block is the test access port front end of a debug port. A host drives a test clock, a mode-select line and a serial data input. It reads the serial output. A sixteen-state controller follows the mode-select line on every rising test-clock edge. Depending on the state, the block loads, shifts or commits either a 4-bit instruction scan chain or the data scan chain that the current instruction picks. The serial input feeds the most significant end of the active chain. The least significant end drives the serial output.

Three data registers hang off the data chain. The first is a fixed 32-bit identification word that cannot be written. The second is a one-bit bypass stage. The third is a user register that can be read and written; its width is a parameter. An asynchronous active-low reset returns only the state controller to its reset state. The instruction and data registers keep their contents. The idle state has no side effects, so a host may park there for as long as it likes while the clock keeps running.

Top module: `jtag_scan_port`

## Requirements
- R1: In the instruction capture state, the instruction chain loads 4'b0001. On each rising edge spent in the instruction shift state, the chain moves one place toward bit 0 and the serial input enters bit 3. The serial output presents bit 0 first.
- R2: The instruction update state copies the chain into the active instruction. Code 4'b1110 selects the identification register (drSel 1). Code 4'b1010 selects the user register (drSel 2). Every other code, including 4'b1111, selects bypass (drSel 0).
- R3: Each rising edge spent in the reset state makes the active instruction 4'b1110.
- R4: The identification data register captures 32'h4A5C3E2B, with bit 0 always 1, and shifts it out least significant bit first. Data scanned into it is discarded, so the next scan reads the same word.
- R5: The bypass register is one bit wide and captures 0. A bypass data scan therefore returns 0 and then the serial input delayed by one clock.
- R6: The user register captures its current value into the data chain. The data update state writes the shifted-in bits into the register, with the first bit in landing in bit 0.
- R7: The serial output and its enable change only on falling clock edges. The enable is high only while the controller is in a shift state. Otherwise the output is held at 0 with the enable low.
- R8: Five rising edges with mode-select high reach the reset state from each of the sixteen states. One further edge with mode-select low then reaches idle, and a normal data scan reads the identification word.
- R9: If the five-high sequence passes through the data update state, the user register is still written.
- R10: Pulling the asynchronous reset low drops the output enable at once, without a clock edge. It leaves the user register unchanged, even when the reset arrives partway through a data shift.
- R11: While the controller rests in idle, neither the active instruction nor the user register changes and the output stays disabled, however many clocks pass.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trstN | input | 1 | Asynchronous active-low reset of the state controller |
| tmsIn | input | 1 | Mode select, sampled on rising tck |
| tdiIn | input | 1 | Serial scan input |
| tdoOut | output | 1 | Serial scan output, updated on falling tck |
| tdoEn | output | 1 | Output enable for tdoOut, high only while shifting |
| curInstr | output | IR_W | Active instruction |
| drSel | output | 2 | Decoded data register selection: 0 bypass, 1 identification, 2 user |

## Verification
The bench uses the default parameters: a 4-bit instruction, an 8-bit user register and a 32-bit identification word. With these sizes the bench can load all sixteen instruction codes and run a complete data scan under each one within a few thousand clocks. The short user register keeps every read-modify-write scan brief. That leaves room to drive the controller into each of its sixteen states and then reset it with five high mode-select edges. Under the same parameters the bench also interrupts a data shift with the asynchronous reset and shows that the user register kept its contents.

// File: rtl/jtag_scan_pkg.sv
package jtag_scan_pkg;

  typedef enum logic [3:0] {
    TAP_RESET,
    TAP_IDLE,
    TAP_SEL_DR,
    TAP_CAP_DR,
    TAP_SHIFT_DR,
    TAP_EXIT1_DR,
    TAP_PAUSE_DR,
    TAP_EXIT2_DR,
    TAP_UPD_DR,
    TAP_SEL_IR,
    TAP_CAP_IR,
    TAP_SHIFT_IR,
    TAP_EXIT1_IR,
    TAP_PAUSE_IR,
    TAP_EXIT2_IR,
    TAP_UPD_IR
  } tapState_e;

  typedef enum logic [1:0] {
    SEL_BYPASS = 2'd0,
    SEL_ID     = 2'd1,
    SEL_USER   = 2'd2
  } drSel_e;

  // Strobes handed from the controller to the datapath; each names
  // the state the controller is currently in.
  typedef struct packed {
    logic inReset;
    logic captureIr;
    logic shiftIr;
    logic updateIr;
    logic captureDr;
    logic shiftDr;
    logic updateDr;
  } scanStrobe_t;

  function automatic tapState_e tapNext(input tapState_e cur, input logic tms);
    tapState_e nxt;
    case (cur)
      TAP_RESET:    nxt = tms ? TAP_RESET    : TAP_IDLE;
      TAP_IDLE:     nxt = tms ? TAP_SEL_DR   : TAP_IDLE;
      TAP_SEL_DR:   nxt = tms ? TAP_SEL_IR   : TAP_CAP_DR;
      TAP_CAP_DR:   nxt = tms ? TAP_EXIT1_DR : TAP_SHIFT_DR;
      TAP_SHIFT_DR: nxt = tms ? TAP_EXIT1_DR : TAP_SHIFT_DR;
      TAP_EXIT1_DR: nxt = tms ? TAP_UPD_DR   : TAP_PAUSE_DR;
      TAP_PAUSE_DR: nxt = tms ? TAP_EXIT2_DR : TAP_PAUSE_DR;
      TAP_EXIT2_DR: nxt = tms ? TAP_UPD_DR   : TAP_SHIFT_DR;
      TAP_UPD_DR:   nxt = tms ? TAP_SEL_DR   : TAP_IDLE;
      TAP_SEL_IR:   nxt = tms ? TAP_RESET    : TAP_CAP_IR;
      TAP_CAP_IR:   nxt = tms ? TAP_EXIT1_IR : TAP_SHIFT_IR;
      TAP_SHIFT_IR: nxt = tms ? TAP_EXIT1_IR : TAP_SHIFT_IR;
      TAP_EXIT1_IR: nxt = tms ? TAP_UPD_IR   : TAP_PAUSE_IR;
      TAP_PAUSE_IR: nxt = tms ? TAP_EXIT2_IR : TAP_PAUSE_IR;
      TAP_EXIT2_IR: nxt = tms ? TAP_UPD_IR   : TAP_SHIFT_IR;
      TAP_UPD_IR:   nxt = tms ? TAP_SEL_DR   : TAP_IDLE;
      default:      nxt = TAP_RESET;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/jtag_tap_ctrl.sv
module jtag_tap_ctrl
  import jtag_scan_pkg::*;
(
  input  logic        tck,
  input  logic        trstN,
  input  logic        tmsIn,
  output scanStrobe_t strobes
);

  tapState_e tapState;

  // Only this register sees the asynchronous reset.
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) tapState <= TAP_RESET;
    else        tapState <= tapNext(tapState, tmsIn);
  end

  always_comb begin
    strobes           = '0;
    strobes.inReset   = (tapState == TAP_RESET);
    strobes.captureIr = (tapState == TAP_CAP_IR);
    strobes.shiftIr   = (tapState == TAP_SHIFT_IR);
    strobes.updateIr  = (tapState == TAP_UPD_IR);
    strobes.captureDr = (tapState == TAP_CAP_DR);
    strobes.shiftDr   = (tapState == TAP_SHIFT_DR);
    strobes.updateDr  = (tapState == TAP_UPD_DR);
  end

  AST_FIVE_HIGH_RESET: assert property (@(posedge tck) disable iff (!trstN)
    (tmsIn && $past(tmsIn) && $past(tmsIn, 2) && $past(tmsIn, 3) && $past(tmsIn, 4))
      |=> (tapState == TAP_RESET)); // R8

  AST_RESET_TO_IDLE: assert property (@(posedge tck) disable iff (!trstN)
    (tapState == TAP_RESET && !tmsIn) |=> (tapState == TAP_IDLE)); // R8

  AST_IDLE_HOLD: assert property (@(posedge tck) disable iff (!trstN)
    (tapState == TAP_IDLE && !tmsIn) |=> (tapState == TAP_IDLE)); // R11

endmodule

// File: rtl/jtag_scan_dp.sv
module jtag_scan_dp
  import jtag_scan_pkg::*;
#(
  parameter int              IR_W       = 4,
  parameter int              USER_W     = 8,
  parameter logic [31:0]     ID_VALUE   = 32'h4A5C3E2B,
  parameter logic [IR_W-1:0] CODE_ID    = 4'b1110,
  parameter logic [IR_W-1:0] CODE_USER  = 4'b1010,
  parameter logic [IR_W-1:0] CAPTURE_IR = 4'b0001
) (
  input  logic            tck,
  input  logic            trstN,
  input  logic            tdiIn,
  input  scanStrobe_t     strobes,
  output logic            tdoOut,
  output logic            tdoEn,
  output logic [IR_W-1:0] curInstr,
  output logic [1:0]      drSel
);

  localparam int              ID_W    = 32;
  localparam int              DR_W    = (ID_W > USER_W) ? ID_W : USER_W;
  localparam int              IDX_W   = $clog2(DR_W);
  localparam logic [ID_W-1:0] ID_WORD = ID_VALUE | 32'd1;

  typedef logic [IDX_W-1:0] drIdx_t;

  logic [IR_W-1:0]   irChain;
  logic [IR_W-1:0]   irActive;
  logic [DR_W-1:0]   drChain;
  logic [DR_W-1:0]   drShifted;
  logic [USER_W-1:0] userReg;
  drSel_e            selCode;
  drIdx_t            topIdx;

  // Instruction decode: unassigned codes fall back to bypass.
  always_comb begin
    if (irActive == CODE_ID)        selCode = SEL_ID;
    else if (irActive == CODE_USER) selCode = SEL_USER;
    else                            selCode = SEL_BYPASS;
  end

  // Index of the chain bit that receives the serial input.
  always_comb begin
    case (selCode)
      SEL_ID:   topIdx = drIdx_t'(ID_W - 1);
      SEL_USER: topIdx = drIdx_t'(USER_W - 1);
      default:  topIdx = '0;
    endcase
  end

  for (genvar b = 0; b < DR_W; b++) begin : g_drBit
    if (b == DR_W - 1) begin : g_msb
      assign drShifted[b] = tdiIn;
    end else begin : g_mid
      assign drShifted[b] = (topIdx == drIdx_t'(b)) ? tdiIn : drChain[b + 1];
    end
  end

  // Instruction scan chain.
  always_ff @(posedge tck) begin
    if (strobes.captureIr)    irChain <= CAPTURE_IR;
    else if (strobes.shiftIr) irChain <= {tdiIn, irChain[IR_W-1:1]};
  end

  // Active instruction: the reset state selects the identification code.
  always_ff @(posedge tck) begin
    if (strobes.inReset)       irActive <= CODE_ID;
    else if (strobes.updateIr) irActive <= irChain;
  end

  // Shared data scan chain.
  always_ff @(posedge tck) begin
    if (strobes.captureDr) begin
      case (selCode)
        SEL_ID:   drChain <= DR_W'(ID_WORD);
        SEL_USER: drChain <= DR_W'(userReg);
        default:  drChain <= '0;
      endcase
    end else if (strobes.shiftDr) begin
      drChain <= drShifted;
    end
  end

  // Only the user register accepts updates.
  always_ff @(posedge tck) begin
    if (strobes.updateDr && selCode == SEL_USER) userReg <= drChain[USER_W-1:0];
  end

  // Serial output on the falling edge, enabled only while shifting.
  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN) begin
      tdoOut <= 1'b0;
      tdoEn  <= 1'b0;
    end else if (strobes.shiftIr) begin
      tdoOut <= irChain[0];
      tdoEn  <= 1'b1;
    end else if (strobes.shiftDr) begin
      tdoOut <= drChain[0];
      tdoEn  <= 1'b1;
    end else begin
      tdoOut <= 1'b0;
      tdoEn  <= 1'b0;
    end
  end

  assign curInstr = irActive;
  assign drSel    = selCode;

  AST_TDO_ONLY_SHIFT: assert property (@(posedge tck) disable iff (!trstN)
    tdoEn |-> (strobes.shiftIr || strobes.shiftDr)); // R7

  AST_IR_COMMIT: assert property (@(posedge tck) disable iff (!trstN)
    strobes.updateIr |=> (irActive == $past(irChain))); // R2

  AST_RESET_SELECTS_ID: assert property (@(posedge tck) disable iff (!trstN)
    strobes.inReset |=> (irActive == CODE_ID)); // R3

  AST_ID_CAPTURE: assert property (@(posedge tck) disable iff (!trstN)
    (strobes.captureDr && selCode == SEL_ID) |=> (drChain[ID_W-1:0] == ID_WORD)); // R4

  AST_USER_HOLD: assert property (@(posedge tck) disable iff (!trstN)
    !(strobes.updateDr && selCode == SEL_USER) |=> $stable(userReg)); // R6

endmodule

// File: rtl/jtag_scan_port.sv
module jtag_scan_port
  import jtag_scan_pkg::*;
#(
  parameter int              IR_W       = 4,
  parameter int              USER_W     = 8,
  parameter logic [31:0]     ID_VALUE   = 32'h4A5C3E2B,
  parameter logic [IR_W-1:0] CODE_ID    = 4'b1110,
  parameter logic [IR_W-1:0] CODE_USER  = 4'b1010,
  parameter logic [IR_W-1:0] CAPTURE_IR = 4'b0001
) (
  input  logic            tck,
  input  logic            trstN,
  input  logic            tmsIn,
  input  logic            tdiIn,
  output logic            tdoOut,
  output logic            tdoEn,
  output logic [IR_W-1:0] curInstr,
  output logic [1:0]      drSel
);

  scanStrobe_t strobes;

  jtag_tap_ctrl u_ctrl (
    .tck     (tck),
    .trstN   (trstN),
    .tmsIn   (tmsIn),
    .strobes (strobes)
  );

  jtag_scan_dp #(
    .IR_W       (IR_W),
    .USER_W     (USER_W),
    .ID_VALUE   (ID_VALUE),
    .CODE_ID    (CODE_ID),
    .CODE_USER  (CODE_USER),
    .CAPTURE_IR (CAPTURE_IR)
  ) u_dp (
    .tck      (tck),
    .trstN    (trstN),
    .tdiIn    (tdiIn),
    .strobes  (strobes),
    .tdoOut   (tdoOut),
    .tdoEn    (tdoEn),
    .curInstr (curInstr),
    .drSel    (drSel)
  );

endmodule

// File: tb/jtag_scan_port_tb.sv
`timescale 1ns/1ps
module jtag_scan_port_tb;

  localparam logic [31:0] ID_WORD   = 32'h4A5C3E2B;
  localparam logic [3:0]  CODE_ID   = 4'b1110;
  localparam logic [3:0]  CODE_USER = 4'b1010;

  logic       tck = 1'b0;
  logic       trstN = 1'b0;
  logic       tmsIn = 1'b1;
  logic       tdiIn = 1'b0;
  logic       tdoOut;
  logic       tdoEn;
  logic [3:0] curInstr;
  logic [1:0] drSel;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic  expBit;
    string tag;
  } sbItem_t;
  sbItem_t sbQ[$];

  // Navigation from idle to each state, mode-select bits first-applied in bit 0.
  int         navLen[16] = '{3, 0, 1, 2, 3, 3, 4, 5, 4, 2, 3, 4, 4, 5, 6, 5};
  logic [7:0] navTms[16] = '{8'd7, 8'd0, 8'd1, 8'd1, 8'd1, 8'd5, 8'd5, 8'd21,
                             8'd13, 8'd3, 8'd3, 8'd3, 8'd11, 8'd11, 8'd43, 8'd27};

  jtag_scan_port u_dut (
    .tck      (tck),
    .trstN    (trstN),
    .tmsIn    (tmsIn),
    .tdiIn    (tdiIn),
    .tdoOut   (tdoOut),
    .tdoEn    (tdoEn),
    .curInstr (curInstr),
    .drSel    (drSel)
  );

  always #2 tck = ~tck;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [1:0] expSel(input logic [3:0] code);
    if (code == 4'b1110) return 2'd1;
    if (code == 4'b1010) return 2'd2;
    return 2'd0;
  endfunction

  // Monitor: one output bit per falling edge while enabled.
  initial begin
    forever begin
      sbItem_t it;
      @(negedge tck);
      #1;
      if (tdoEn === 1'b1 && sbQ.size() > 0) begin
        it = sbQ.pop_front();
        check(tdoOut === it.expBit, it.tag, "serial bit", 64'(tdoOut), 64'(it.expBit));
      end
    end
  end

  task automatic tick(input logic tms, input logic tdi);
    tmsIn = tms;
    tdiIn = tdi;
    @(posedge tck);
    #1;
  endtask

  // Driver: full scan from idle back to idle, pushing expected output bits.
  task automatic scan(input bit isIr, input int n, input logic [63:0] din,
                      input logic [63:0] dexp, input bit care, input string tag);
    if (care) for (int i = 0; i < n; i++) sbQ.push_back('{dexp[i], tag});
    tick(1'b1, 1'b0);
    if (isIr) tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
    tick(1'b0, 1'b0);
    for (int i = 0; i < n; i++) tick(i == n - 1, din[i]);
    tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
    check(sbQ.size() == 0, tag, "scan bits consumed", 64'(sbQ.size()), 64'd0);
    sbQ.delete();
  endtask

  task automatic setIr(input logic [3:0] code);
    scan(1'b1, 4, 64'(code), 64'h1, 1'b1, "R1");
    check(curInstr === code, "R2", "active instruction", 64'(curInstr), 64'(code));
  endtask

  task automatic fiveHigh();
    for (int i = 0; i < 5; i++) tick(1'b1, 1'b0);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge tck);
    checks++;
    fails++;
    $display("FAIL watchdog: actual still running expected completed run");
    finishRun();
  end

  initial begin
    // Reset state
    trstN = 1'b0;
    tmsIn = 1'b1;
    repeat (3) @(posedge tck);
    #1;
    check(tdoEn === 1'b0, "R7", "enable in reset", 64'(tdoEn), 64'd0);
    check(tdoOut === 1'b0, "R7", "idle output in reset", 64'(tdoOut), 64'd0);
    trstN = 1'b1;
    tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
    check(curInstr === CODE_ID, "R3", "instruction after reset", 64'(curInstr), 64'(CODE_ID));
    check(drSel === 2'd1, "R2", "selection after reset", 64'(drSel), 64'd1);

    // R4: identification read, write ignored
    scan(1'b0, 32, 64'h0F0F_F0F0, 64'(ID_WORD), 1'b1, "R4");
    scan(1'b0, 32, 64'h0, 64'(ID_WORD), 1'b1, "R4");

    // R1, R2, R5, R6: every instruction code
    for (int code = 0; code < 16; code++) begin
      setIr(4'(code));
      check(drSel === expSel(4'(code)), "R2", "decoded selection", 64'(drSel),
            64'(expSel(4'(code))));
      case (expSel(4'(code)))
        2'd1: scan(1'b0, 32, 64'h1234_5678, 64'(ID_WORD), 1'b1, "R4");
        2'd2: begin
          scan(1'b0, 8, 64'hC3, 64'h0, 1'b0, "R6");
          scan(1'b0, 8, 64'h96, 64'hC3, 1'b1, "R6");
        end
        default: scan(1'b0, 9, 64'h16B, 64'h0D6, 1'b1, "R5");
      endcase
    end

    // R11: rest in idle
    setIr(CODE_USER);
    scan(1'b0, 8, 64'h3C, 64'h0, 1'b0, "R11");
    for (int i = 0; i < 60; i++) begin
      tick(1'b0, i[0]);
      check(tdoEn === 1'b0 && tdoOut === 1'b0, "R11", "output idle while resting",
            64'({tdoEn, tdoOut}), 64'd0);
    end
    check(curInstr === CODE_USER, "R11", "instruction after rest", 64'(curInstr),
          64'(CODE_USER));
    scan(1'b0, 8, 64'h3C, 64'h3C, 1'b1, "R11");

    // R9: five-high exit from Exit1-DR passes the data update
    tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
    tick(1'b0, 1'b0);
    for (int i = 0; i < 8; i++) tick(i == 7, 1'((8'hA5 >> i) & 8'h1));
    fiveHigh();
    tick(1'b0, 1'b0);
    check(curInstr === CODE_ID, "R9", "instruction after five highs", 64'(curInstr),
          64'(CODE_ID));
    setIr(CODE_USER);
    scan(1'b0, 8, 64'hA5, 64'hA5, 1'b1, "R9");

    // R8: five highs from each of the sixteen states
    for (int s = 0; s < 16; s++) begin
      setIr(CODE_USER);
      for (int k = 0; k < navLen[s]; k++) tick(navTms[s][k], 1'b0);
      fiveHigh();
      tick(1'b0, 1'b0);
      check(curInstr === CODE_ID, "R8", $sformatf("instruction, start state %0d", s),
            64'(curInstr), 64'(CODE_ID));
      scan(1'b0, 32, 64'h0, 64'(ID_WORD), 1'b1, "R8");
    end

    // R10: asynchronous reset in the middle of a data shift
    setIr(CODE_USER);
    scan(1'b0, 8, 64'h5A, 64'h0, 1'b0, "R10");
    tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
    tick(1'b0, 1'b0);
    for (int i = 0; i < 3; i++) tick(1'b0, 1'b1);
    check(tdoEn === 1'b1, "R7", "enable while shifting", 64'(tdoEn), 64'd1);
    trstN = 1'b0;
    #0.5;
    check(tdoEn === 1'b0, "R10", "enable drops without clock", 64'(tdoEn), 64'd0);
    tick(1'b0, 1'b0);
    tick(1'b0, 1'b0);
    trstN = 1'b1;
    tick(1'b0, 1'b0);
    check(curInstr === CODE_ID, "R3", "instruction after async reset", 64'(curInstr),
          64'(CODE_ID));
    setIr(CODE_USER);
    scan(1'b0, 8, 64'h5A, 64'h5A, 1'b1, "R10");

    finishRun();
  end

endmodule